// File: doc/BRIEF.md
# Asynchronous NOR Memory Access Sequencer

This block accepts one read or write request at a time from an internal bus and plays it out as a timed access to an external parallel NOR memory. The memory has separate address and data pins. Each access starts with an address setup phase. A data phase follows, in which either the output-enable strobe or the write-enable strobe is low. Both phase lengths are decoded from 32-bit timing words and counted in system clock cycles. After chip-select rises, the block enforces a turnaround gap before it can start another access.

A mode input selects between two timing schemes. When it is low, every access uses the primary timing word. When it is high, writes use a second timing word and reads keep the primary one. A bank-enable input gates the whole block. A request that arrives while the bank is off is answered at once with an error pulse and causes no activity on the memory pins.

Top module: `nor_seq_top`

## Requirements
- R1: After reset, chip-select, output-enable and write-enable are high, the data drivers are off (`mem_dq_oe` = 0) and `req_ready` is high.
- R2: The address phase lasts exactly the value in timing-word bits 3:0, counted in cycles. During this phase chip-select is low and both strobes are high. A value of 0 skips the phase entirely.
- R3: The data phase lasts exactly the value in timing-word bits 15:8, counted in cycles, and a value of 0 gives one cycle. During this phase `mem_oe_n` is low for a read and `mem_we_n` is low for a write. The two strobes are never low at the same time.
- R4: A read captures `mem_dq_in` on the last clock edge of the data phase. In the first cycle that chip-select is high again, `rsp_done` is high for exactly one cycle and `rsp_rdata` holds the captured value.
- R5: For a write, `mem_dq_oe` is high and `mem_dq_out` equals the request data in every cycle that chip-select is low. For a read, `mem_dq_oe` stays low.
- R6: When a request is already waiting, chip-select stays high for exactly (timing-word bits 19:16) + 1 cycles between two accesses. The extra cycle is the acceptance cycle.
- R7: When `ext_mode` = 1, writes take their timing from `tim_wr` and reads take their timing from `tim_rd`.
- R8: When `ext_mode` = 0, `tim_wr` has no effect and every access is timed by `tim_rd`.
- R9: Timing-word bits 7:4, 31:20 have no effect on any phase length.
- R10: A request accepted while `bank_en` = 0 produces a one-cycle `rsp_err` pulse in the next cycle and does not drive chip-select low.
- R11: `mem_addr` equals the request address and does not change while chip-select is low.
- R12: `req_ready` is high only when the block is idle. It is low during the address phase, the data phase and the turnaround gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en | input | 1 | Enables accesses to the memory bank |
| ext_mode | input | 1 | Selects separate write timing |
| tim_rd | input | 32 | Primary timing word |
| tim_wr | input | 32 | Write timing word, used only when `ext_mode` = 1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (24) | Request address |
| req_wdata | input | DW (16) | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle error pulse when the bank is disabled |
| rsp_rdata | output | DW (16) | Captured read data |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_addr | output | AW (24) | Memory address |
| mem_dq_out | output | DW (16) | Data driven to the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DW (16) | Data returned by the memory |

## Verification
The hardest condition to reach from the ports is an exact turnaround measurement. It needs a second request already waiting at the moment chip-select rises, together with a timing word that differs from the one that will time the next access. The bench issues its transactions back to back from the same falling edge on which the previous completion is observed, so no idle slack enters the measured gap. It also mixes extended-mode writes with primary-timed reads, so that consecutive accesses draw their phase lengths and turnaround values from different timing words. Zero-length address and data phases are forced in directed cases, and random garbage fills the ignored timing fields throughout.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int TIM_W      = 32;
    localparam int SETUP_LSB  = 0;
    localparam int SETUP_W    = 4;
    localparam int DATA_LSB   = 8;
    localparam int DATA_W     = 8;
    localparam int TURN_LSB   = 16;
    localparam int TURN_W     = 4;
    localparam int CNT_W      = DATA_W;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [DATA_W-1:0]  data;
        logic [TURN_W-1:0]  turn;
    } nor_tim_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } nor_st_t;

    // Extract the phase lengths; a zero data length is stretched to one cycle.
    function automatic nor_tim_t decode_tim(input logic [TIM_W-1:0] w);
        nor_tim_t t;
        t.setup = w[SETUP_LSB +: SETUP_W];
        t.data  = (w[DATA_LSB +: DATA_W] == '0) ? DATA_W'(1) : w[DATA_LSB +: DATA_W];
        t.turn  = w[TURN_LSB +: TURN_W];
        return t;
    endfunction

endpackage

// File: rtl/nor_seq_timsel.sv
module nor_seq_timsel
    import nor_seq_pkg::*;
(
    input  logic             ext_mode,
    input  logic             is_write,
    input  logic [TIM_W-1:0] tim_rd,
    input  logic [TIM_W-1:0] tim_wr,
    output nor_tim_t         tim
);
    logic [TIM_W-1:0] chosen;
    logic             unused_fields;

    always_comb begin
        chosen = (ext_mode && is_write) ? tim_wr : tim_rd;
        tim    = decode_tim(chosen);
    end

    // Hold, divide, latency and mode fields play no part in asynchronous timing.
    assign unused_fields = ^{chosen[31:20], chosen[7:4]};

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     bank_en,
    input  nor_tim_t tim,
    output nor_st_t  state,
    output logic     accept,
    output logic     last_data,
    output logic     done_pulse,
    output logic     err_pulse
);
    logic [CNT_W-1:0] cnt;
    nor_tim_t         tim_q;

    assign accept    = (state == ST_IDLE) && req_valid && bank_en;
    assign last_data = (state == ST_DATA) && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            tim_q      <= '0;
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && !bank_en) begin
                        err_pulse <= 1'b1;
                    end else if (accept) begin
                        tim_q <= tim;
                        if (tim.setup != '0) begin
                            state <= ST_ADDR;
                            cnt   <= CNT_W'(tim.setup);
                        end else begin
                            state <= ST_DATA;
                            cnt   <= tim.data;
                        end
                    end
                end
                ST_ADDR: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_DATA;
                        cnt   <= tim_q.data;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (cnt == CNT_W'(1)) begin
                        done_pulse <= 1'b1;
                        if (tim_q.turn != '0) begin
                            state <= ST_GAP;
                            cnt   <= CNT_W'(tim_q.turn);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nor_seq_pins.sv
module nor_seq_pins
    import nor_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  nor_st_t       state,
    input  logic          last_data,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    output logic [DW-1:0] rdata
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wr_q;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wr_q    <= req_write;
            end
            if (last_data && !wr_q) begin
                rdata <= mem_dq_in;
            end
        end
    end

    always_comb begin
        active     = (state == ST_ADDR) || (state == ST_DATA);
        mem_ce_n   = !active;
        mem_oe_n   = !((state == ST_DATA) && !wr_q);
        mem_we_n   = !((state == ST_DATA) && wr_q);
        mem_addr   = addr_q;
        mem_dq_out = wdata_q;
        mem_dq_oe  = active && wr_q;
    end

endmodule

// File: rtl/nor_seq_top.sv
module nor_seq_top
    import nor_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank_en,
    input  logic          ext_mode,
    input  logic [31:0]   tim_rd,
    input  logic [31:0]   tim_wr,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    nor_tim_t tim;
    nor_st_t  state;
    logic     accept;
    logic     last_data;

    nor_seq_timsel u_timsel (
        .ext_mode (ext_mode),
        .is_write (req_write),
        .tim_rd   (tim_rd),
        .tim_wr   (tim_wr),
        .tim      (tim)
    );

    nor_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .bank_en    (bank_en),
        .tim        (tim),
        .state      (state),
        .accept     (accept),
        .last_data  (last_data),
        .done_pulse (rsp_done),
        .err_pulse  (rsp_err)
    );

    nor_seq_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .state      (state),
        .last_data  (last_data),
        .mem_dq_in  (mem_dq_in),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .rdata      (rsp_rdata)
    );

    assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          bank_en,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_err,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe
);
    // R3
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    // R3
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n || mem_dq_oe) |-> !mem_ce_n);

    // R4
    done_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (mem_ce_n && !$past(mem_ce_n)));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R10
    err_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (mem_ce_n && !$past(bank_en)));

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready);

endmodule

bind nor_seq_top nor_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bank_en   (bank_en),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/nor_seq_top_test.sv
module nor_seq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_en = 1'b1;
    logic        ext_mode = 1'b0;
    logic [31:0] tim_rd = '0;
    logic [31:0] tim_wr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [23:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;

    int total = 0;
    int fails = 0;
    int hi_cnt = 0;
    int gap_len = 0;
    int prev_turn = -1;

    always #5 clk = ~clk;

    function automatic logic [15:0] pat(input logic [23:0] a);
        return a[15:0] ^ 16'hA55A ^ {8'h00, a[23:16]};
    endfunction

    function automatic logic [31:0] mk(input int s, input int d, input int t, input logic [31:0] junk);
        logic [31:0] w;
        w = junk;
        w[3:0] = 4'(s);
        w[15:8] = 8'(d);
        w[19:16] = 4'(t);
        return w;
    endfunction

    assign mem_dq_in = mem_oe_n ? 16'h0000 : pat(mem_addr);

    nor_seq_top uut (.*);

    always @(negedge clk) begin
        if (mem_ce_n) hi_cnt = hi_cnt + 1;
        else begin
            if (hi_cnt != 0) gap_len = hi_cnt;
            hi_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called and returning on a falling edge.
    task automatic xfer(input bit wr, input logic [23:0] a, input logic [15:0] d);
        logic [31:0] w;
        int es, ed, et, s, dc, guard, exp_gap;
        bit bad_wr, bad_rd, bad_addr, bad_rdy;
        w  = (ext_mode && wr) ? tim_wr : tim_rd;
        es = int'(w[3:0]);
        ed = (w[15:8] == 0) ? 1 : int'(w[15:8]);
        et = int'(w[19:16]);
        exp_gap = (prev_turn >= 0) ? prev_turn + 1 : -1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!bank_en) begin
            chk(rsp_err === 1'b1, "R10 err pulse", rsp_err, 1);
            chk(mem_ce_n === 1'b1, "R10 no chip-select", mem_ce_n, 1);
            @(negedge clk);
            chk(mem_ce_n === 1'b1 && rsp_err === 1'b0, "R10 quiet after err", mem_ce_n, 1);
            prev_turn = -1;
            return;
        end
        s = 0; dc = 0; guard = 0;
        bad_wr = 0; bad_rd = 0; bad_addr = 0; bad_rdy = 0;
        while (!rsp_done && guard < 1000) begin
            if (!mem_ce_n) begin
                if (mem_oe_n && mem_we_n) s++; else dc++;
                if (mem_addr !== a) bad_addr = 1;
                if (req_ready !== 1'b0) bad_rdy = 1;
                if (wr && (!mem_dq_oe || mem_dq_out !== d || !mem_oe_n)) bad_wr = 1;
                if (!wr && (mem_dq_oe || !mem_we_n)) bad_rd = 1;
            end
            guard++;
            @(negedge clk);
        end
        chk(s == es, wr ? "R2/R7/R8/R9 setup write" : "R2/R9 setup read", s, es);
        chk(dc == ed, wr ? "R3/R7/R8/R9 data write" : "R3/R9 data read", dc, ed);
        chk(!bad_addr, "R11 address", bad_addr, 0);
        chk(!bad_rdy, "R12 ready low", bad_rdy, 0);
        chk(mem_ce_n === 1'b1, "R4 done with cs high", mem_ce_n, 1);
        if (wr) chk(!bad_wr, "R5 write data drive", bad_wr, 0);
        else begin
            chk(!bad_rd, "R5 read no drive", bad_rd, 0);
            chk(rsp_rdata === pat(a), "R4 read data", rsp_rdata, pat(a));
        end
        if (exp_gap >= 0) chk(gap_len == exp_gap, "R6 turnaround", gap_len, exp_gap);
        prev_turn = et;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(mem_dq_oe === 1'b0, "R1 drivers off", mem_dq_oe, 0);
        chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);

        // Directed: plain read, then write with tim_wr garbage (R8)
        tim_rd = mk(2, 3, 2, 32'h0);
        tim_wr = mk(9, 9, 7, 32'h0);
        xfer(1'b0, 24'h12_3456, 16'h0);
        xfer(1'b1, 24'h00_0F0F, 16'hBEEF);
        // Zero setup and zero data length (R2, R3)
        tim_rd = mk(0, 0, 0, 32'h0);
        xfer(1'b0, 24'hAB_CDEF, 16'h0);
        xfer(1'b1, 24'h00_1111, 16'h1234);
        // Extended mode: writes from tim_wr, reads from tim_rd (R7)
        ext_mode = 1'b1;
        tim_rd = mk(1, 2, 3, 32'h0);
        tim_wr = mk(5, 4, 0, 32'h0);
        xfer(1'b1, 24'h55_AA55, 16'hCAFE);
        xfer(1'b0, 24'h33_0001, 16'h0);
        xfer(1'b1, 24'h44_0002, 16'h0F0F);
        // Ignored fields full of ones (R9)
        ext_mode = 1'b0;
        tim_rd = mk(3, 2, 1, 32'hFFFF_FFFF);
        xfer(1'b0, 24'h77_7777, 16'h0);
        // Bank disabled (R10)
        bank_en = 1'b0;
        xfer(1'b1, 24'h01_0203, 16'h9999);
        bank_en = 1'b1;
        xfer(1'b0, 24'h01_0203, 16'h0);

        // Random mix with fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 80; i++) begin
            ext_mode = 1'($urandom);
            tim_rd = mk($urandom % 16, $urandom % 9, $urandom % 6, $urandom);
            tim_wr = mk($urandom % 16, $urandom % 9, $urandom % 6, $urandom);
            if (($urandom % 16) == 0) begin
                bank_en = 1'b0;
                xfer(1'($urandom), 24'($urandom), 16'($urandom));
                bank_en = 1'b1;
            end else begin
                xfer(1'($urandom), 24'($urandom), 16'($urandom));
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule